// File: doc/BRIEF.md
# Interval Timer with Two Byte-Loaded Compare Points

This block is a free-running up-counter with two compare points. Compare point 1 sets the period: when the counter reaches its value, a match pulse is raised and the counter restarts from zero on the next clock. Compare point 0 marks an intermediate instant inside that period and leaves the counter alone. Both compare values are loaded over a narrow data port that carries half of a compare value per write. The low half is written first and the high half second.

Compare point 0 can be placed behind a staging buffer. With the buffer selected, software fills the buffer at any time. The buffer moves into the live compare point only at a period match, and only when both of its halves have been marked as written since the last move. The two written-marks are independent, so a stale high half combined with a fresh low half is moved as a mixed value. That behaviour is deliberate and is reproduced.

A compare point whose full value has never been written stays disarmed after reset and never matches.

Top module: `cmp_timer`

## Requirements
- R1: While `run_i` is high the counter advances by one on every clock, wrapping from all-ones to zero; while `run_i` is low it is forced to zero on the next clock and held there.
- R2: `match_o[1]` is high when `run_i` is high, compare point 1 is armed and the counter equals its value; the counter is zero on the clock after such a match, giving a period of value+1 clocks.
- R3: `match_o[0]` is high when `run_i` is high, compare point 0 is armed and the counter equals its value; it does not alter the count.
- R4: A write is a cycle with `wr_en_i` high; `wr_sel_i`=0 addresses compare point 0, 1 addresses compare point 1; `wr_hi_i`=0 writes the low half, 1 the high half. A direct high-half write loads {high, latest low} into the live value, effective from the next clock.
- R5: After reset the counter is zero and both compare points are disarmed, so no match appears as the counter passes through every value.
- R6: A compare point becomes armed only by a high-half write that follows at least one low-half write since reset (or by a buffer move); low-half writes alone, or a high-half write with no prior low half, leave it disarmed.
- R7: While `dbuf_en_i` is high, writes to compare point 0 go to the staging buffer and leave the live value unchanged until a move.
- R8: A move happens on a clock where `dbuf_en_i` is high, `match_o[1]` is high and both written-marks are set. It copies {buffer high, buffer low} into compare point 0, arms it, and clears both marks. A buffer write in the same clock sets its own mark and data after the move.
- R9: After a move, writing only one half sets only that half's mark, and later period matches move nothing.
- R10: A high-half mark left over from an earlier write, combined with a newly written low half, causes the next period match to move the mixed value {old high, new low}.
- R11: While `dbuf_en_i` is low, compare point 0 is written directly as in R4, and no move happens even if both marks are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Counter run control |
| dbuf_en_i | input | 1 | Selects staging-buffer loading for compare point 0 |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Compare point select |
| wr_hi_i | input | 1 | Half select: 0 low, 1 high |
| wr_data_i | input | CNT_W/2 | Write data half |
| count_o | output | CNT_W | Current counter value |
| match_o | output | 2 | Match flags, index = compare point |

## Verification
The assertions take for granted that the data inputs are stable around each sampling edge. They also assume the buffer-enable control is treated as a level that is valid in the cycle of any compare point 0 write, since the buffer-isolation property keys on its value in that cycle. The bench drives every input on the falling edge and holds it for a whole clock. It changes the buffer mode only between writes and only while no period match is pending. Each write is a single-cycle strobe, so no two halves are ever presented in the same cycle.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int NUM_CMP    = 2;
  localparam int MID_IDX    = 0;
  localparam int PERIOD_IDX = 1;

  typedef enum logic {
    SEL_MID    = 1'b0,
    SEL_PERIOD = 1'b1
  } cmp_sel_e;
endpackage

// File: rtl/ct_rst_sync.sv
module ct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)     cnt_d = '0;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ct_cmp_reg.sv
module ct_cmp_reg #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_hi,
  input  logic [H-1:0] wr_data,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         arm
);
  logic [H-1:0] lo_hold_q, lo_hold_d;
  logic [W-1:0] val_q, val_d;
  logic         lo_seen_q, lo_seen_d;
  logic         arm_q, arm_d;
  logic         lo_en, val_en;

  always_comb begin
    lo_hold_d = lo_hold_q;
    lo_seen_d = lo_seen_q;
    val_d     = val_q;
    arm_d     = arm_q;
    lo_en     = 1'b0;
    val_en    = 1'b0;
    if (ld_en) begin
      val_d  = ld_val;
      arm_d  = 1'b1;
      val_en = 1'b1;
    end
    if (wr_en && !wr_hi) begin
      lo_hold_d = wr_data;
      lo_seen_d = 1'b1;
      lo_en     = 1'b1;
    end
    if (wr_en && wr_hi && lo_seen_q) begin
      val_d  = {wr_data, lo_hold_q};
      arm_d  = 1'b1;
      val_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_seen_q <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      lo_seen_q <= lo_seen_d;
      arm_q     <= arm_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_en)  lo_hold_q <= lo_hold_d;
    if (val_en) val_q     <= val_d;
  end

  assign val = val_q;
  assign arm = arm_q;
endmodule

// File: rtl/ct_stage_buf.sv
module ct_stage_buf #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_hi,
  input  logic [H-1:0] wr_data,
  input  logic         xfer_req,
  output logic         xfer,
  output logic [W-1:0] buf_val
);
  logic [H-1:0] lo_q, hi_q;
  logic         flo_q, flo_d, fhi_q, fhi_d;
  logic         lo_en, hi_en;

  assign xfer  = xfer_req && flo_q && fhi_q;
  assign lo_en = wr_en && !wr_hi;
  assign hi_en = wr_en && wr_hi;

  always_comb begin
    flo_d = flo_q;
    fhi_d = fhi_q;
    if (xfer) begin
      flo_d = 1'b0;
      fhi_d = 1'b0;
    end
    if (lo_en) flo_d = 1'b1;
    if (hi_en) fhi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flo_q <= 1'b0;
      fhi_q <= 1'b0;
    end else begin
      flo_q <= flo_d;
      fhi_q <= fhi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_en) lo_q <= wr_data;
    if (hi_en) hi_q <= wr_data;
  end

  assign buf_val = {hi_q, lo_q};
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer import ct_pkg::*; #(
  parameter int CNT_W = 16,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              dbuf_en_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [NUM_CMP-1:0] match_o
);
  logic               rst_sync_n;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cmp_val [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_arm;
  logic [NUM_CMP-1:0] hit;
  logic               buf_wr, buf_xfer;
  logic [CNT_W-1:0]   buf_val;
  logic [CNT_W-1:0]   cmp0_val;
  logic               cmp0_arm, cmp1_arm;

  ct_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ct_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run_i),
    .clr   (hit[PERIOD_IDX]),
    .cnt   (cnt)
  );

  assign buf_wr = wr_en_i && (wr_sel_i == SEL_MID) && dbuf_en_i;

  ct_stage_buf #(.W(CNT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (buf_wr),
    .wr_hi    (wr_hi_i),
    .wr_data  (wr_data_i),
    .xfer_req (hit[PERIOD_IDX] && dbuf_en_i),
    .xfer     (buf_xfer),
    .buf_val  (buf_val)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic             dir_wr;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    if (i == MID_IDX) begin : g_buffered
      assign dir_wr = wr_en_i && (wr_sel_i == SEL_MID) && !dbuf_en_i;
      assign ld     = buf_xfer;
      assign ld_val = buf_val;
    end else begin : g_direct
      assign dir_wr = wr_en_i && (wr_sel_i == SEL_PERIOD);
      assign ld     = 1'b0;
      assign ld_val = '0;
    end

    ct_cmp_reg #(.W(CNT_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (dir_wr),
      .wr_hi   (wr_hi_i),
      .wr_data (wr_data_i),
      .ld_en   (ld),
      .ld_val  (ld_val),
      .val     (cmp_val[i]),
      .arm     (cmp_arm[i])
    );

    assign hit[i] = run_i && cmp_arm[i] && (cnt == cmp_val[i]);
  end

  assign cmp0_val = cmp_val[MID_IDX];
  assign cmp0_arm = cmp_arm[MID_IDX];
  assign cmp1_arm = cmp_arm[PERIOD_IDX];
  assign count_o  = cnt;
  assign match_o  = hit;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_i,
  input logic         dbuf_en_i,
  input logic         wr_en_i,
  input logic         wr_sel_i,
  input logic         wr_hi_i,
  input logic [W-1:0] count_o,
  input logic [1:0]   match_o,
  input logic [W-1:0] cmp0_val,
  input logic         cmp0_arm,
  input logic         cmp1_arm
);
  // R1: stopped counter reads zero next clock
  assert_stop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> count_o == '0);

  // R1: running counter without a period match steps by one
  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !match_o[1]) |=> count_o == W'($past(count_o) + 1'b1));

  // R2: period match restarts the count
  assert_period_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && match_o[1]) |=> count_o == '0);

  // R3: no match of either kind while stopped
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> match_o == 2'b00);

  // R6: period compare arms only through a high-half write
  assert_arm1_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp1_arm) |-> $past(wr_en_i && wr_sel_i && wr_hi_i));

  // R8: compare point 0 arms only through a direct high write or a move at a period match
  assert_arm0_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp0_arm) |-> ($past(wr_en_i && !wr_sel_i && wr_hi_i && !dbuf_en_i)
                         || $past(match_o[1] && dbuf_en_i)));

  // R7: buffered mode keeps the live value unless a period match occurs
  assert_buffer_isolates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en_i && !match_o[1] && cmp0_arm) |=> $stable(cmp0_val));
endmodule

bind cmp_timer ct_checker #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .run_i     (run_i),
  .dbuf_en_i (dbuf_en_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_hi_i   (wr_hi_i),
  .count_o   (count_o),
  .match_o   (match_o),
  .cmp0_val  (cmp0_val),
  .cmp0_arm  (cmp0_arm),
  .cmp1_arm  (cmp1_arm)
);

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
  localparam int W   = 8;
  localparam int H   = W / 2;
  localparam int MOD = 1 << W;
  localparam int HM  = 1 << H;

  logic         clk;
  logic         rst_n;
  logic         run_i, dbuf_en_i, wr_en_i, wr_sel_i, wr_hi_i;
  logic [H-1:0] wr_data_i;
  logic [W-1:0] count_o;
  logic [1:0]   match_o;

  int n_vec = 0;
  int n_bad = 0;

  // reference state, derived from the requirements
  int m_cnt;
  int m_r [2];
  int m_a [2];
  int m_lh [2];
  int m_ls [2];
  int b_lo, b_hi, f_lo, f_hi;

  cmp_timer #(.CNT_W(W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_i),
    .dbuf_en_i (dbuf_en_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .match_o   (match_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_match(int i);
    return (run_i && m_a[i] && (m_cnt == m_r[i])) ? 1 : 0;
  endfunction

  task automatic tick(string tag);
    int m1, xf, d;
    m1 = exp_match(1);
    xf = (m1 && dbuf_en_i && f_lo && f_hi) ? 1 : 0;
    d  = int'(wr_data_i);
    m_cnt = (!run_i || m1) ? 0 : (m_cnt + 1) % MOD;
    for (int i = 0; i < 2; i++) begin
      if (wr_en_i && (int'(wr_sel_i) == i) && !(i == 0 && dbuf_en_i)) begin
        if (!wr_hi_i) begin
          m_lh[i] = d;
          m_ls[i] = 1;
        end else if (m_ls[i]) begin
          m_r[i] = d * HM + m_lh[i];
          m_a[i] = 1;
        end
      end
    end
    if (xf) begin
      m_r[0] = b_hi * HM + b_lo;
      m_a[0] = 1;
      f_lo = 0;
      f_hi = 0;
    end
    if (wr_en_i && !wr_sel_i && dbuf_en_i) begin
      if (wr_hi_i) begin b_hi = d; f_hi = 1; end
      else         begin b_lo = d; f_lo = 1; end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "count", int'(count_o), m_cnt);
    chk(tag, "match1", int'(match_o[1]), exp_match(1));
    chk(tag, "match0", int'(match_o[0]), exp_match(0));
  endtask

  task automatic wr(string tag, bit sel, bit hi, int data);
    wr_en_i   = 1'b1;
    wr_sel_i  = sel;
    wr_hi_i   = hi;
    wr_data_i = H'(data);
    tick(tag);
    wr_en_i   = 1'b0;
  endtask

  task automatic load(string tag, bit sel, int val);
    wr(tag, sel, 1'b0, val % HM);
    wr(tag, sel, 1'b1, (val / HM) % HM);
  endtask

  task automatic run_for(string tag, int n);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_i = 1'b0; dbuf_en_i = 1'b0;
    wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_hi_i = 1'b0; wr_data_i = '0;
    m_cnt = 0; b_lo = 0; b_hi = 0; f_lo = 0; f_hi = 0;
    for (int i = 0; i < 2; i++) begin
      m_r[i] = 0; m_a[i] = 0; m_lh[i] = 0; m_ls[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: reset state, then a full wrap with nothing armed
    chk("R5", "count after reset", int'(count_o), 0);
    chk("R5", "match after reset", int'(match_o), 0);
    run_i = 1'b1;
    run_for("R5", MOD + 10);

    // R6: low halves alone, and a high half with no prior low, do not arm
    wr("R6", 1'b1, 1'b0, 5);
    wr("R6", 1'b0, 1'b1, 3);
    run_for("R6", MOD + 10);

    // R1: stopping holds zero, restarting counts from zero
    run_i = 1'b0;
    run_for("R1", 5);
    run_i = 1'b1;
    run_for("R1", 20);

    // R2, R3, R4: sweep of periods and intermediate points, direct mode
    for (int p = 0; p <= 40; p++) begin
      load("R4", 1'b1, p);
      load("R4", 1'b0, p / 2);
      run_for("R2", 2 * p + 5);
    end
    load("R3", 1'b0, 200);
    load("R2", 1'b1, MOD - 1);
    run_for("R2", 2 * MOD + 4);

    // R7, R8: staged value stays out until the period match moves it
    load("R7", 1'b1, 32);
    load("R7", 1'b0, 3);
    dbuf_en_i = 1'b1;
    load("R7", 1'b0, 7);
    run_for("R8", 80);

    // R9: after a move, a lone high half moves nothing
    wr("R9", 1'b0, 1'b1, 1);
    run_for("R9", 80);

    // R10: stale high mark plus new low half moves the mixed value 0x14
    wr("R10", 1'b0, 1'b0, 4);
    run_for("R10", 80);

    // R11: both marks set, but direct mode blocks the move; direct load works
    load("R11", 1'b0, 26);
    dbuf_en_i = 1'b0;
    run_for("R11", 80);
    load("R11", 1'b0, 9);
    run_for("R11", 80);

    summary();
    $finish;
  end
endmodule